// File: doc/BRIEF.md
# Dual-Edge Channel Interrupt Request Generator

This block turns two digital input lines of one I/O channel into a single interrupt request. The low line of the pair asks for service on a low-to-high transition, and the other asks for service on a high-to-low transition. Both are sampled on a local clock through a synchronizer. Each accepted transition produces a request pulse of fixed length on the sample clock.

Whether transitions count at all depends on a static policy selection. The policy can force requests on, force them off, or hand the decision to software. Under software control, a third port line acts as an active-low enable.

The request leaves the block as a value plus a separate output enable. Several channels or boards can then share one open request wire, and the block drives that wire only while it is asserting. A drive-permit input models the channel's control bits being switched back to input direction. Dropping it releases the wire and cancels any pulse in progress. No record is kept of which line fired. Software finds the source by reading the present line levels.

Top module: `edge_irq_gen`

## Requirements
- R1: A low-to-high transition on `rise_src` produces `irq_out` high for exactly PULSE_LEN consecutive clocks, starting on the (SYNC_STAGES+1)-th rising clock edge after the change, when requests are enabled and `drive_en` is 1.
- R2: A high-to-low transition on `fall_src` produces the same pulse with the same latency as in R1.
- R3: A high-to-low transition on `rise_src`, a low-to-high transition on `fall_src`, or steady levels on both produce no request.
- R4: When `en_policy` is 2'b00 (software control), a transition is accepted while `gate_n` is 0 and ignored while `gate_n` is 1.
- R5: When `en_policy` is 2'b01, every qualifying transition is accepted whatever `gate_n` is. When `en_policy` is 2'b10 or 2'b11, no request is ever raised.
- R6: A transition that arrives while requests are disabled is dropped. Enabling requests afterwards, with the line still at its new level, raises no request.
- R7: An accepted transition during a running pulse restarts the count, so `irq_out` stays high until PULSE_LEN clocks after the last accepted transition.
- R8: `irq_oe` is 1 exactly on the clocks where the block is asserting the request (`irq_out` is 1 and `drive_en` is 1). It is 0 at all other times.
- R9: While `drive_en` is 0, `irq_oe` is 0 in that same clock, the pulse counter is cleared at the next edge, and no transition is accepted. Restoring `drive_en` does not resume a cancelled pulse.
- R10: During reset and after it, with both lines at their idle levels (`rise_src` 0, `fall_src` 1), `irq_out` and `irq_oe` are 0.
- R11: Holding a line at its active level after one accepted transition gives no further request. The line must return to its idle level before it can trigger again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rise_src | input | 1 | Line watched for low-to-high transitions (idle low) |
| fall_src | input | 1 | Line watched for high-to-low transitions (idle high) |
| gate_n | input | 1 | Active-low software enable, used when `en_policy` is 2'b00 |
| en_policy | input | 2 | 00 software, 01 always on, 10 and 11 always off |
| drive_en | input | 1 | Channel control bits are outputs; 0 releases the shared wire |
| irq_out | output | 1 | Request value, high during a pulse |
| irq_oe | output | 1 | Output enable for the shared request wire |

## Verification
The bound checker watches several properties on every clock:
- No pulse starts without an accepted transition.
- A running pulse never outlasts PULSE_LEN clocks after its last load, and every pulse that is not cut short runs to exactly that length.
- The wire is never driven while no request is asserted.
- Dropping the drive permit empties the counter by the next clock.
- The force-off policy never lets a pulse begin.

Only the bench's scenarios can show the rest:
- The exact start latency.
- Which transition direction on which line counts.
- That a disabled transition is forgotten rather than held over.
- That a held line triggers only once.

The bench shows these by sweeping every policy, gate level, permit level and transition pattern.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   typedef enum logic [1:0] {
      POL_SOFT    = 2'b00,
      POL_ALWAYS  = 2'b01,
      POL_NEVER   = 2'b10,
      POL_NEVER_B = 2'b11
   } irq_policy_e;

   // Transitions count when the policy permits it.
   function automatic logic policy_allows(input logic [1:0] pol, input logic gate_n_s);
      logic ok;
      case (irq_policy_e'(pol))
         POL_SOFT:   ok = ~gate_n_s;
         POL_ALWAYS: ok = 1'b1;
         default:    ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
      end else begin
         stage_q[0] <= d_in;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
   parameter int               WIDTH     = 2,
   parameter logic [WIDTH-1:0] RISE_MASK = 2'b01,
   parameter logic [WIDTH-1:0] IDLE_VAL  = 2'b10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] hit
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_VAL;
      else        prev_q <= lvl;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (RISE_MASK[b]) begin : g_rise
         assign hit[b] = lvl[b] & ~prev_q[b];
      end else begin : g_fall
         assign hit[b] = ~lvl[b] & prev_q[b];
      end
   end

endmodule

// File: rtl/edge_irq_stretch.sv
module edge_irq_stretch #(
   parameter int PULSE_LEN = 4,
   localparam int CW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clr,
   output logic active
);

   if (PULSE_LEN == 1) begin : g_single
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   flag_q <= 1'b0;
         else if (clr) flag_q <= 1'b0;
         else          flag_q <= load;
      end
      assign active = flag_q;
   end else begin : g_count
      localparam logic [CW-1:0] LEN_V = CW'(PULSE_LEN);
      logic [CW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (clr)            left_q <= '0;
         else if (load)           left_q <= LEN_V;
         else if (left_q != '0)   left_q <= left_q - 1'b1;
      end
      assign active = (left_q != '0);
   end

endmodule

// File: rtl/edge_irq_gen.sv
module edge_irq_gen #(
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_LEN   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rise_src,
   input  logic       fall_src,
   input  logic       gate_n,
   input  logic [1:0] en_policy,
   input  logic       drive_en,
   output logic       irq_out,
   output logic       irq_oe
);
   import edge_irq_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_irq_gen: SYNC_STAGES must be at least 2");
   end
   if (PULSE_LEN < 1) begin : g_bad_len
      $error("edge_irq_gen: PULSE_LEN must be at least 1");
   end

   // bit 2 gate (idle disabled), bit 1 fall line (idle high), bit 0 rise line
   localparam logic [2:0] SYNC_IDLE = 3'b110;

   logic [2:0] raw_lvl, syn_lvl;
   logic [1:0] edge_hit;
   logic       allow;
   logic       arm_evt;
   logic       pulse_on;

   assign raw_lvl = {gate_n, fall_src, rise_src};

   edge_irq_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in (raw_lvl),
      .q_out(syn_lvl)
   );

   edge_irq_detect #(
      .WIDTH    (2),
      .RISE_MASK(2'b01),
      .IDLE_VAL (SYNC_IDLE[1:0])
   ) u_detect (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (syn_lvl[1:0]),
      .hit  (edge_hit)
   );

   assign allow   = policy_allows(en_policy, syn_lvl[2]) & drive_en;
   assign arm_evt = (|edge_hit) & allow;

   edge_irq_stretch #(
      .PULSE_LEN(PULSE_LEN)
   ) u_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (arm_evt),
      .clr   (~drive_en),
      .active(pulse_on)
   );

   assign irq_out = pulse_on;
   assign irq_oe  = pulse_on & drive_en;

endmodule

module edge_irq_chk #(
   parameter int PULSE_LEN = 4,
   localparam int RW = $clog2(PULSE_LEN + 2)
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] en_policy,
   input logic       drive_en,
   input logic       arm_evt,
   input logic       irq_out,
   input logic       irq_oe
);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (arm_evt) run_q <= '0;
      else if (irq_out) run_q <= run_q + 1'b1;
      else              run_q <= '0;
   end

   // R10
   no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(arm_evt));

   // R7
   pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (run_q < RW'(PULSE_LEN)));

   // R1
   full_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_out) && $past(drive_en) && !$past(arm_evt)) |-> (run_q == RW'(PULSE_LEN)));

   // R8
   no_idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> !irq_oe);

   // R9
   release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |=> !irq_out);

   // R5
   forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_policy[1] && $past(en_policy[1]) && !$past(irq_out)) |-> !irq_out);

endmodule

bind edge_irq_gen edge_irq_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_policy(en_policy),
   .drive_en (drive_en),
   .arm_evt  (arm_evt),
   .irq_out  (irq_out),
   .irq_oe   (irq_oe)
);

// File: tb/sim_edge_irq_gen.sv
module sim_edge_irq_gen;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int PLEN       = 4;
   localparam int WIN        = SYNC + PLEN + 5;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rise_src, fall_src, gate_n, drive_en;
   logic [1:0] en_policy;
   logic       irq_out, irq_oe;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   edge_irq_gen #(.SYNC_STAGES(SYNC), .PULSE_LEN(PLEN)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_src (rise_src),
      .fall_src (fall_src),
      .gate_n   (gate_n),
      .en_policy(en_policy),
      .drive_en (drive_en),
      .irq_out  (irq_out),
      .irq_oe   (irq_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic report_done();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
         report_done();
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // counts high cycles, first high index, and oe mismatches over WIN edges
   task automatic observe(output int highs, output int first, output int oe_bad);
      highs = 0; first = 0; oe_bad = 0;
      for (int i = 1; i <= WIN; i++) begin
         @(posedge clk);
         #1;
         if (irq_out) begin
            highs++;
            if (first == 0) first = i;
         end
         if (irq_oe !== (irq_out & drive_en)) oe_bad++;
      end
      @(negedge clk);
   endtask

   int h, f, ob;

   initial begin
      rst_n = 1'b0; rise_src = 1'b0; fall_src = 1'b1; gate_n = 1'b1;
      en_policy = 2'b01; drive_en = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      check("R10 irq_out in reset", int'(irq_out), 0);
      check("R10 irq_oe in reset", int'(irq_oe), 0);
      @(negedge clk);
      rst_n = 1'b1;
      observe(h, f, ob);
      check("R10 no request after reset with idle lines", h, 0);

      // sweep: policy x gate x permit x pattern (0 none,1 rise,2 fall,3 both)
      for (int pol = 0; pol < 4; pol++) begin
         for (int g = 0; g < 2; g++) begin
            for (int d = 0; d < 2; d++) begin
               for (int pat = 0; pat < 4; pat++) begin
                  bit en_ok, fire;
                  rise_src = 1'b0; fall_src = 1'b1;
                  en_policy = 2'(pol); gate_n = g[0]; drive_en = d[0];
                  wait_cyc(SYNC + PLEN + 3);
                  en_ok = (pol == 1) || (pol == 0 && g == 0);
                  fire  = (pat != 0) && en_ok && (d == 1);
                  if (pat[0]) rise_src = 1'b1;
                  if (pat[1]) fall_src = 1'b0;
                  observe(h, f, ob);
                  // R1 R2 R3 R4 R5 R9
                  check($sformatf("R1/R2 R4 R5 pulse length pol=%0d gate=%0d drv=%0d pat=%0d", pol, g, d, pat),
                        h, fire ? PLEN : 0);
                  check($sformatf("R1/R2 start latency pol=%0d gate=%0d drv=%0d pat=%0d", pol, g, d, pat),
                        f, fire ? SYNC + 1 : 0);
                  check($sformatf("R8 oe tracks request pol=%0d gate=%0d drv=%0d pat=%0d", pol, g, d, pat),
                        ob, 0);
                  // R11 line held at active level: nothing more
                  if (fire) begin
                     observe(h, f, ob);
                     check($sformatf("R11 held line retriggers pat=%0d", pat), h, 0);
                  end
               end
            end
         end
      end

      // R3 wrong-direction transitions
      en_policy = 2'b01; drive_en = 1'b1; gate_n = 1'b0;
      rise_src = 1'b1; fall_src = 1'b0;
      wait_cyc(SYNC + PLEN + 3);
      rise_src = 1'b0;
      observe(h, f, ob);
      check("R3 falling transition on rise_src", h, 0);
      fall_src = 1'b1;
      observe(h, f, ob);
      check("R3 rising transition on fall_src", h, 0);

      // R6 disabled transition is forgotten
      en_policy = 2'b00; gate_n = 1'b1; rise_src = 1'b0; fall_src = 1'b1;
      wait_cyc(SYNC + 3);
      rise_src = 1'b1;
      wait_cyc(SYNC + 2);
      gate_n = 1'b0;
      observe(h, f, ob);
      check("R6 request after late enable", h, 0);
      rise_src = 1'b0;
      wait_cyc(SYNC + 2);
      rise_src = 1'b1;
      observe(h, f, ob);
      check("R4 accepted once gate low", h, PLEN);

      // R7 retrigger during a pulse
      en_policy = 2'b01; rise_src = 1'b0; fall_src = 1'b1;
      wait_cyc(SYNC + PLEN + 3);
      rise_src = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      fall_src = 1'b0;
      h = 0; f = 0;
      for (int i = 3; i <= WIN + 2; i++) begin
         @(posedge clk); #1;
         if (irq_out) begin h++; if (f == 0) f = i; end
      end
      @(negedge clk);
      check("R7 restarted pulse length", h, PLEN + 2);
      check("R7 restarted pulse start", f, SYNC + 1);

      // R9 release mid-pulse
      rise_src = 1'b0; fall_src = 1'b1;
      wait_cyc(SYNC + PLEN + 3);
      rise_src = 1'b1;
      for (int i = 0; i < SYNC + 2; i++) @(posedge clk);
      #1;
      check("R9 pulse running before release", int'(irq_oe), 1);
      @(negedge clk);
      drive_en = 1'b0;
      #1;
      check("R9 oe drops in same cycle", int'(irq_oe), 0);
      @(posedge clk); #1;
      check("R9 counter cleared next edge", int'(irq_out), 0);
      @(negedge clk);
      drive_en = 1'b1;
      observe(h, f, ob);
      check("R9 cancelled pulse does not resume", h, 0);

      report_done();
   end

endmodule